// File: doc/BRIEF.md
# Permission-Split Direct-Mapped Address Translator

This block translates virtual addresses to physical addresses through a direct-mapped table of 256 entries. Each entry has one shared physical page base and three separate tags, one for each access kind: load, store and instruction fetch. Access rights are not stored as bits. A kind is allowed on a page only when that kind's own tag holds the page. A lookup compares only the tag of its own kind. On a hit, the physical address appears in the same cycle. On a miss, the block raises a single refill request and keeps it up until an external responder returns a page-table entry.

The returned entry fills each of the three tags on its own, according to its read, write and execute rights. A tag whose right is missing gets the all-ones pattern, which no lookup can match. The refill is refused in two cases. If the entry is invalid, or lacks the right the pending access needs, the block reports an access fault. If the physical page overlaps a watched physical range, the block reports the translated access on a trace port and writes nothing, so that page misses again every time. Loading a new watched range clears the whole table, and so does an explicit flush request.

Top module: `perm_split_tlb`

## Requirements
- R1: After reset every entry of all three tags is invalid, no refill request is pending, and the first lookup of any address misses.
- R2: The entry index is bits [19:12] of the virtual address (the low 8 bits of the virtual page number). A lookup hits only if the whole 20-bit virtual page number equals the one stored, so two pages that share an index displace each other.
- R3: The access kind is coded as 00 for load, 01 for store, and 1x for fetch. A lookup compares only against the tag of its own kind. On a hit, lkHit is 1 in the same cycle and lkPaddr is the stored page number shifted left by 12, joined with virtual address bits [11:0].
- R4: A lookup that misses while no refill is pending raises refReq on the next cycle, with refVaddr set to the lookup address. refReq stays high with a stable address until rspValid arrives. No lookup reports a hit while refReq is high. refReq is low on the cycle after the response.
- R5: The response entry (rspPte) has valid at bit 0, read at bit 1, write at bit 2, execute at bit 3, and the physical page number in bits [31:10]. A granted refill writes the page number to the base and writes the load, store and fetch tags if read, write and execute are set. Each tag whose right is clear becomes invalid.
- R6: If the entry is invalid, or lacks the right for the pending kind, faultValid pulses in the response cycle and nothing is written. faultStore is 1 only for a store; load and fetch faults report 0.
- R7: If the granted physical page [ppn*4096, ppn*4096+4096) overlaps the watched range [monLo, monHi), trcValid pulses in the response cycle. trcPaddr is the translated address and trcKind is the pending kind. Nothing is written, so the same lookup misses again.
- R8: A monSet pulse loads monLo and monHi and invalidates every entry.
- R9: flushReq invalidates every entry at the next clock edge. If a refill arrives in the same cycle, the flush wins and the refill is not kept.
- R10: The watched range is half-open. A page that ends exactly at monLo, or starts exactly at monHi, is not watched and is filled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Invalidate all entries |
| lkValid | input | 1 | Lookup request, held until hit, fault or trace |
| lkKind | input | 2 | Access kind: 00 load, 01 store, 1x fetch |
| lkVaddr | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit this cycle |
| lkPaddr | output | 34 | Translated physical address on a hit |
| refReq | output | 1 | Refill request pending |
| refVaddr | output | 32 | Virtual address awaiting refill |
| rspValid | input | 1 | Refill response strobe |
| rspPte | input | 32 | Page-table entry for the response |
| faultValid | output | 1 | Access fault pulse |
| faultStore | output | 1 | Fault belongs to a store |
| monSet | input | 1 | Load the watched range and flush |
| monLo | input | 34 | Watched range start (inclusive) |
| monHi | input | 34 | Watched range end (exclusive) |
| trcValid | output | 1 | Trace pulse for a watched-page access |
| trcPaddr | output | 34 | Traced physical address |
| trcKind | output | 2 | Kind of the traced access |

## Verification
A table-wide flush and a refill write can land on the same clock edge. They write the same tag storage, so one must win. The bench provokes this by raising flushReq in the same cycle as a granted rspValid. It then looks up the same address and requires a fresh miss and refill request. A second collision is a watched-range update that arrives while entries are valid. That case is judged by checking that translations which hit before the update miss after it.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int BIT_VALID = 0;
  localparam int BIT_RD    = 1;

  typedef struct packed {
    logic capture;
    logic fill;
    logic flush;
  } tlbStrobe_t;

  typedef struct packed {
    logic hit;
    logic grant;
    logic watched;
  } tlbStatus_t;

  function automatic logic [1:0] kindToArray(input logic [1:0] kind);
    if (kind[1])      return 2'd2;
    else if (kind[0]) return 2'd1;
    else              return 2'd0;
  endfunction
endpackage

// File: rtl/ptlb_datapath.sv
module ptlb_datapath
  import ptlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256,
  parameter int PTE_BITS   = 32,
  parameter int PPN_LSB    = 10,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int TAG_W     = VPN_W + 1,
  localparam int PPN_W     = PTE_BITS - PPN_LSB,
  localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  tlbStrobe_t          stb,
  output tlbStatus_t          sts,
  input  logic [VA_W-1:0]     lkVaddr,
  input  logic [1:0]          lkKind,
  input  logic [PTE_BITS-1:0] rspPte,
  input  logic                monSet,
  input  logic [PA_W-1:0]     monLo,
  input  logic [PA_W-1:0]     monHi,
  output logic [PA_W-1:0]     lkPaddr,
  output logic [PA_W-1:0]     trcPaddr,
  output logic [VA_W-1:0]     refVaddr,
  output logic [1:0]          pendKind
);
  localparam logic [PA_W:0] PAGE_SPAN = {{PA_W{1'b0}}, 1'b1} << PAGE_SHIFT;

  logic [VA_W-1:0]  pendVaddr;
  logic [PA_W-1:0]  monLoR, monHiR;
  logic [IDX_W-1:0] lkIdx, pendIdx;
  logic [TAG_W-1:0] lkTag, pendTag;
  logic [PPN_W-1:0] rspPpn;
  logic [TAG_W-1:0] rdTag [3];
  logic [PPN_W-1:0] baseMem [ENTRIES];
  logic             unusedPteBits;

  assign lkIdx   = lkVaddr[PAGE_SHIFT +: IDX_W];
  assign pendIdx = pendVaddr[PAGE_SHIFT +: IDX_W];
  // a cleared-offset marker bit keeps the all-ones pattern unmatchable
  assign lkTag   = {lkVaddr[VA_W-1:PAGE_SHIFT], 1'b0};
  assign pendTag = {pendVaddr[VA_W-1:PAGE_SHIFT], 1'b0};
  assign rspPpn  = rspPte[PTE_BITS-1:PPN_LSB];
  assign unusedPteBits = ^rspPte[PPN_LSB-1:BIT_RD+3];

  // pending request and watched range
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendVaddr <= '0;
      pendKind  <= 2'b00;
      monLoR    <= '0;
      monHiR    <= '0;
    end else begin
      if (stb.capture) begin
        pendVaddr <= lkVaddr;
        pendKind  <= lkKind;
      end
      if (monSet) begin
        monLoR <= monLo;
        monHiR <= monHi;
      end
    end
  end

  // one tag array per access kind: 0 load, 1 store, 2 fetch
  for (genvar a = 0; a < 3; a++) begin : gTag
    logic [TAG_W-1:0] mem [ENTRIES];
    always_ff @(posedge clk) begin
      if (!rstN || stb.flush) begin
        for (int i = 0; i < ENTRIES; i++) mem[i] <= '1;
      end else if (stb.fill) begin
        mem[pendIdx] <= (rspPte[BIT_VALID] && rspPte[BIT_RD + a]) ? pendTag : '1;
      end
    end
    assign rdTag[a] = mem[lkIdx];
  end

  always_ff @(posedge clk) begin
    if (stb.fill && !stb.flush) baseMem[pendIdx] <= rspPpn;
  end

  logic [TAG_W-1:0] selTag;
  logic             permBit;
  logic [PA_W:0]    pgLo, pgHi;

  always_comb begin
    case (kindToArray(lkKind))
      2'd1:    selTag = rdTag[1];
      2'd2:    selTag = rdTag[2];
      default: selTag = rdTag[0];
    endcase
    case (kindToArray(pendKind))
      2'd1:    permBit = rspPte[BIT_RD + 1];
      2'd2:    permBit = rspPte[BIT_RD + 2];
      default: permBit = rspPte[BIT_RD];
    endcase
    pgLo = {1'b0, rspPpn, {PAGE_SHIFT{1'b0}}};
    pgHi = pgLo + PAGE_SPAN;
    sts.hit     = (selTag == lkTag);
    sts.grant   = rspPte[BIT_VALID] && permBit;
    sts.watched = (pgLo < {1'b0, monHiR}) && (pgHi > {1'b0, monLoR});
  end

  assign lkPaddr  = {baseMem[lkIdx], lkVaddr[PAGE_SHIFT-1:0]};
  assign trcPaddr = {rspPpn, pendVaddr[PAGE_SHIFT-1:0]};
  assign refVaddr = pendVaddr;
endmodule

// File: rtl/ptlb_ctrl.sv
module ptlb_ctrl
  import ptlb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic       rspValid,
  input  logic       flushReq,
  input  logic       monSet,
  input  logic [1:0] pendKind,
  input  tlbStatus_t sts,
  output tlbStrobe_t stb,
  output logic       lkHit,
  output logic       refReq,
  output logic       faultValid,
  output logic       faultStore,
  output logic       trcValid
);
  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_e;
  ctrlState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb         = '0;
    stb.flush   = flushReq || monSet;
    lkHit       = 1'b0;
    faultValid  = 1'b0;
    trcValid    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (lkValid) begin
          if (sts.hit) begin
            lkHit = 1'b1;
          end else begin
            stb.capture = 1'b1;
            nextState   = ST_WAIT;
          end
        end
      end
      default: begin
        if (rspValid) begin
          if (!sts.grant)       faultValid = 1'b1;
          else if (sts.watched) trcValid   = 1'b1;
          else                  stb.fill   = 1'b1;
          nextState = ST_IDLE;
        end
      end
    endcase
  end

  assign refReq     = (state == ST_WAIT);
  assign faultStore = faultValid && (pendKind == 2'b01);
endmodule

// File: rtl/perm_split_tlb.sv
module perm_split_tlb
  import ptlb_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256,
  parameter int PTE_BITS   = 32,
  parameter int PPN_LSB    = 10,
  localparam int PA_W      = PTE_BITS - PPN_LSB + PAGE_SHIFT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flushReq,
  input  logic                lkValid,
  input  logic [1:0]          lkKind,
  input  logic [VA_W-1:0]     lkVaddr,
  output logic                lkHit,
  output logic [PA_W-1:0]     lkPaddr,
  output logic                refReq,
  output logic [VA_W-1:0]     refVaddr,
  input  logic                rspValid,
  input  logic [PTE_BITS-1:0] rspPte,
  output logic                faultValid,
  output logic                faultStore,
  input  logic                monSet,
  input  logic [PA_W-1:0]     monLo,
  input  logic [PA_W-1:0]     monHi,
  output logic                trcValid,
  output logic [PA_W-1:0]     trcPaddr,
  output logic [1:0]          trcKind
);
  tlbStrobe_t stb;
  tlbStatus_t sts;
  logic [1:0] pendKind;

  ptlb_datapath #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .ENTRIES(ENTRIES),
    .PTE_BITS(PTE_BITS), .PPN_LSB(PPN_LSB)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sts(sts),
    .lkVaddr(lkVaddr), .lkKind(lkKind), .rspPte(rspPte),
    .monSet(monSet), .monLo(monLo), .monHi(monHi),
    .lkPaddr(lkPaddr), .trcPaddr(trcPaddr), .refVaddr(refVaddr),
    .pendKind(pendKind)
  );

  ptlb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .rspValid(rspValid),
    .flushReq(flushReq), .monSet(monSet), .pendKind(pendKind), .sts(sts),
    .stb(stb), .lkHit(lkHit), .refReq(refReq), .faultValid(faultValid),
    .faultStore(faultStore), .trcValid(trcValid)
  );

  assign trcKind = pendKind;
endmodule

// File: rtl/perm_split_tlb_chk.sv
module perm_split_tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 34
) (
  input logic            clk,
  input logic            rstN,
  input logic            flushReq,
  input logic            monSet,
  input logic            lkValid,
  input logic [VA_W-1:0] lkVaddr,
  input logic            lkHit,
  input logic            refReq,
  input logic [VA_W-1:0] refVaddr,
  input logic            rspValid,
  input logic            faultValid,
  input logic            faultStore,
  input logic            trcValid
);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && !rspValid |=> refReq && $stable(refVaddr));
  // R4
  no_hit_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> !lkHit);
  // R4
  miss_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && !lkHit && !refReq |=> refReq && refVaddr == $past(lkVaddr));
  // R4
  rsp_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq && rspValid |=> !refReq);
  // R6
  fault_when_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> refReq && rspValid && !trcValid);
  // R6
  fault_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStore |-> faultValid);
  // R7
  trace_when_chk: assert property (@(posedge clk) disable iff (!rstN)
    trcValid |-> refReq && rspValid);
  // R9
  flush_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushReq || monSet |=> !lkHit);
endmodule

bind perm_split_tlb perm_split_tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) uChk (
  .clk(clk), .rstN(rstN), .flushReq(flushReq), .monSet(monSet),
  .lkValid(lkValid), .lkVaddr(lkVaddr), .lkHit(lkHit), .refReq(refReq),
  .refVaddr(refVaddr), .rspValid(rspValid), .faultValid(faultValid),
  .faultStore(faultStore), .trcValid(trcValid)
);

// File: tb/tb_perm_split_tlb.sv
`timescale 1ns/1ps
module tb_perm_split_tlb;
  localparam logic [1:0] K_LOAD = 2'b00, K_STORE = 2'b01, K_FETCH = 2'b10;
  localparam logic [31:0] VA_A = 32'h0001_2345;
  localparam logic [31:0] VA_B = 32'h0011_2345;
  localparam logic [31:0] VA_C = 32'h0001_3abc;
  localparam logic [31:0] VA_D = 32'h0004_5010;

  logic clk = 1'b0;
  logic rstN, flushReq, lkValid, rspValid, monSet;
  logic [1:0]  lkKind;
  logic [31:0] lkVaddr, rspPte;
  logic [33:0] monLo, monHi;
  logic lkHit, refReq, faultValid, faultStore, trcValid;
  logic [33:0] lkPaddr, trcPaddr;
  logic [31:0] refVaddr;
  logic [1:0]  trcKind;
  int total = 0, bad = 0;
  logic [1:0]  curKind;
  logic [31:0] curVa;

  always #2.5 clk = ~clk;

  perm_split_tlb dut (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .lkValid(lkValid),
    .lkKind(lkKind), .lkVaddr(lkVaddr), .lkHit(lkHit), .lkPaddr(lkPaddr),
    .refReq(refReq), .refVaddr(refVaddr), .rspValid(rspValid), .rspPte(rspPte),
    .faultValid(faultValid), .faultStore(faultStore), .monSet(monSet),
    .monLo(monLo), .monHi(monHi), .trcValid(trcValid), .trcPaddr(trcPaddr),
    .trcKind(trcKind)
  );

  function automatic logic [31:0] mkPte(input logic [21:0] ppn, input bit v, input bit r,
                                        input bit w, input bit x);
    return {ppn, 6'd0, x, w, r, v};
  endfunction

  function automatic logic [33:0] xlate(input logic [21:0] ppn, input logic [31:0] va);
    return (34'(ppn) << 12) | 34'(va & 32'hfff);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expectHit(input logic [31:0] va, input logic [1:0] kind,
                           input logic [33:0] expPa, input string req);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkKind = kind;
    #1;
    check(lkHit === 1'b1, {req, " hit"}, 64'(lkHit), 64'd1);
    check(lkPaddr === expPa, {req, " paddr"}, 64'(lkPaddr), 64'(expPa));
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  task automatic expectMiss(input logic [31:0] va, input logic [1:0] kind, input string req);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = va; lkKind = kind;
    curKind = kind; curVa = va;
    #1;
    check(lkHit === 1'b0, {req, " miss"}, 64'(lkHit), 64'd0);
    @(negedge clk);
    #1;
    check(refReq === 1'b1, {req, " refReq"}, 64'(refReq), 64'd1);
    check(refVaddr === va, {req, " refVaddr"}, 64'(refVaddr), 64'(va));
  endtask

  task automatic respond(input logic [31:0] pte, input bit withFlush, input bit expFault,
                         input bit expFaultStore, input bit expTrc, input logic [33:0] expTrcPa,
                         input string req);
    rspValid = 1'b1; rspPte = pte; flushReq = withFlush;
    #1;
    check(faultValid === expFault, {req, " faultValid"}, 64'(faultValid), 64'(expFault));
    check(faultStore === expFaultStore, {req, " faultStore"}, 64'(faultStore), 64'(expFaultStore));
    check(trcValid === expTrc, {req, " trcValid"}, 64'(trcValid), 64'(expTrc));
    if (expTrc) begin
      check(trcPaddr === expTrcPa, {req, " trcPaddr"}, 64'(trcPaddr), 64'(expTrcPa));
      check(trcKind === curKind, {req, " trcKind"}, 64'(trcKind), 64'(curKind));
    end
    @(negedge clk);
    rspValid = 1'b0; flushReq = 1'b0; lkValid = 1'b0;
    #1;
    check(refReq === 1'b0, "R4 refReq dropped", 64'(refReq), 64'd0);
  endtask

  task automatic setMonitor(input logic [33:0] lo, input logic [33:0] hi);
    @(negedge clk);
    monSet = 1'b1; monLo = lo; monHi = hi;
    @(negedge clk);
    monSet = 1'b0;
  endtask

  task automatic testReset();
    #1;
    check(refReq === 1'b0, "R1 refReq after reset", 64'(refReq), 64'd0);
    check(faultValid === 1'b0 && trcValid === 1'b0, "R1 no pulses", 64'(faultValid), 64'd0);
    expectMiss(VA_A, K_LOAD, "R1");
    respond(mkPte(22'h55, 1, 1, 0, 0), 0, 0, 0, 0, '0, "R5 load fill");
    expectHit(VA_A, K_LOAD, xlate(22'h55, VA_A), "R5 load");
  endtask

  task automatic testKinds();
    expectMiss(VA_A, K_STORE, "R3 store uses own tag");
    respond(mkPte(22'h55, 1, 1, 0, 0), 0, 1, 1, 0, '0, "R6 store fault");
    expectHit(VA_A, K_LOAD, xlate(22'h55, VA_A), "R6 unchanged after fault");
    expectMiss(VA_A, K_FETCH, "R3 fetch uses own tag");
    respond(mkPte(22'h66, 1, 0, 0, 1), 0, 0, 0, 0, '0, "R5 fetch fill");
    expectHit(VA_A, K_FETCH, xlate(22'h66, VA_A), "R5 fetch");
    expectMiss(VA_A, K_LOAD, "R5 read tag cleared");
    respond(mkPte(22'h77, 1, 1, 1, 1), 0, 0, 0, 0, '0, "R5 full fill");
    expectHit(VA_A, K_LOAD,  xlate(22'h77, VA_A), "R3 load");
    expectHit(VA_A, K_STORE, xlate(22'h77, VA_A), "R3 store");
    expectHit(VA_A, 2'b11,   xlate(22'h77, VA_A), "R3 fetch code 11");
  endtask

  task automatic testAlias();
    expectMiss(VA_B, K_LOAD, "R2 alias");
    repeat (3) @(negedge clk);
    #1;
    check(refReq === 1'b1, "R4 held", 64'(refReq), 64'd1);
    check(lkHit === 1'b0, "R4 no hit while waiting", 64'(lkHit), 64'd0);
    respond(mkPte(22'h88, 0, 1, 1, 1), 0, 1, 0, 0, '0, "R6 invalid entry");
    expectHit(VA_A, K_LOAD, xlate(22'h77, VA_A), "R2 entry kept");
    expectMiss(VA_C, K_FETCH, "R2 other index");
    respond(mkPte(22'h12, 1, 1, 0, 0), 0, 1, 0, 0, '0, "R6 fetch fault");
    expectMiss(VA_C, K_LOAD, "R2 other index load");
    respond(mkPte(22'h12, 1, 1, 0, 0), 0, 0, 0, 0, '0, "R5 second fill");
    expectHit(VA_C, K_LOAD, xlate(22'h12, VA_C), "R2 second entry");
  endtask

  task automatic testFlushRace();
    expectMiss(VA_D, K_STORE, "R9 race");
    respond(mkPte(22'h99, 1, 0, 1, 0), 1, 0, 0, 0, '0, "R9 race response");
    expectMiss(VA_D, K_STORE, "R9 flush beat fill");
    respond(mkPte(22'h99, 1, 0, 1, 0), 0, 0, 0, 0, '0, "R9 refill");
    expectHit(VA_D, K_STORE, xlate(22'h99, VA_D), "R9 refill hit");
    expectMiss(VA_A, K_LOAD, "R9 old entry flushed");
    respond(mkPte(22'h77, 1, 1, 0, 0), 0, 0, 0, 0, '0, "R9 refill A");
    expectHit(VA_A, K_LOAD, xlate(22'h77, VA_A), "R9 refill A hit");
  endtask

  task automatic testMonitor();
    setMonitor(34'h20_0000, 34'h20_1000);
    expectMiss(VA_A, K_LOAD, "R8 flush on monitor set");
    respond(mkPte(22'h200, 1, 1, 0, 0), 0, 0, 0, 1, xlate(22'h200, VA_A), "R7 trace");
    expectMiss(VA_A, K_LOAD, "R7 no fill");
    respond(mkPte(22'h1ff, 1, 1, 0, 0), 0, 0, 0, 0, '0, "R10 below range");
    expectHit(VA_A, K_LOAD, xlate(22'h1ff, VA_A), "R10 below range fill");
    expectMiss(VA_C, K_STORE, "R10 above");
    respond(mkPte(22'h201, 1, 0, 1, 0), 0, 0, 0, 0, '0, "R10 at range end");
    expectHit(VA_C, K_STORE, xlate(22'h201, VA_C), "R10 at range end fill");
    expectMiss(VA_D, K_FETCH, "R7 fetch trace");
    respond(mkPte(22'h200, 1, 0, 0, 1), 0, 0, 0, 1, xlate(22'h200, VA_D), "R7 fetch trace");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; flushReq = 1'b0; lkValid = 1'b0; rspValid = 1'b0; monSet = 1'b0;
    lkKind = 2'b00; lkVaddr = '0; rspPte = '0; monLo = '0; monHi = '0;
    curKind = 2'b00; curVa = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testKinds();
    testAlias();
    testFlushRace();
    testMonitor();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule